// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Reset and Slot Engine

This block produces the bit-level timing for the master side of a single-conductor, open-drain serial bus on which sensors share one data line with a pull-up. A higher layer asks it, through a valid/ready handshake, for one of three operations. A bus reset ends with a presence verdict. A single-bit write slot sends a 0 or a 1. A single-bit read slot returns the sampled level. The block then returns a one-cycle response that carries the result.

The block has one pad control, `bus_pull_low`. When this signal is high, the pad pulls the line to ground. When it is low, the pad releases the line to the pull-up. The block never drives a high level. The line level comes back on `bus_in` and passes through a two-flop synchronizer before any decision uses it. All timing is counted in microseconds. The microsecond tick is derived from `CLK_HZ` and restarts at the moment a request is accepted, so every phase lasts a whole number of microseconds from that point. Recovery at the end of each bit slot is the fixed `REC_US` plus a per-request extension `rec_extra_us`, which lengthens slots on heavily loaded cables. Command bytes, addressing and strong pull-up control belong to other blocks.

Top module: `sline_slot_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `bus_pull_low` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The line is only pulled low or released. Whenever no operation is in progress, `bus_pull_low` is 0.
- R3: Operation code `req_op`=2'b00 (bus reset) pulls the line low for RST_LOW_US (480) microseconds, counted from the clock edge that accepts the request. It then releases the line for RST_REL_US (480) microseconds. The response follows 960 microseconds after acceptance.
- R4: During a bus reset, the block watches the synchronized line at each microsecond tick whose elapsed count after acceptance lies in [495, 780), which is 15 to 300 microseconds after release. If the line is seen low at any of these ticks, the response has `rsp_presence`=1 and `rsp_fault`=0. Otherwise it has `rsp_presence`=0 and `rsp_fault`=1.
- R5: Operation code 2'b01 (write) pulls the line low for 6 microseconds when `req_bit`=1 and for 60 microseconds when `req_bit`=0. The response reports `rsp_bit`=0, `rsp_presence`=0 and `rsp_fault`=0.
- R6: Operation codes 2'b10 and 2'b11 (read) pull the line low for 6 microseconds. They sample the synchronized line at elapsed microsecond 15 and return that level in `rsp_bit`, with presence and fault both 0. A device that holds the line low only until microsecond 12 reads as 1.
- R7: A write or read slot lasts SLOT_US+REC_US (70) microseconds plus `rec_extra_us` microseconds. The extension is captured at acceptance and does not affect bus resets.
- R8: `req_ready` is 1 only when idle, and a request made while busy has no effect on the line or the timing. `rsp_valid` is a one-cycle pulse on the cycle in which `req_ready` returns to 1. A request presented in that cycle is accepted at the next edge.
- R9: A synchronous reset during an operation releases the line at that edge and abandons the operation without a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 2 | 00 bus reset, 01 write, 10/11 read |
| req_bit | input | 1 | Bit value for a write |
| rec_extra_us | input | 8 | Extra recovery microseconds for slots |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_bit | output | 1 | Level sampled by a read, else 0 |
| rsp_presence | output | 1 | Presence seen during a bus reset |
| rsp_fault | output | 1 | Bus reset found no presence pulse |
| bus_pull_low | output | 1 | Pad pull-down enable (1 = pull line low) |
| bus_in | input | 1 | Raw line level from the pad |

## Verification
A corrupted microsecond counter or latched limit shows up directly on `bus_pull_low`. The release edge moves by at least one microsecond (50 clocks), or the response strobe and `req_ready` arrive early or late, so a per-clock comparison against a timing model exposes it on the first affected operation. A wrong window bound or sample point is invisible on the line but flips `rsp_presence`, `rsp_fault` or `rsp_bit` at the end of that transaction. The scenarios therefore place device pulses just inside and just outside the watched intervals. If the busy/idle state were wrong, an overlapping request would restart the line pattern mid-slot, and this is visible within the cycle after the stray request.

// File: rtl/sline_pkg.sv
// Shared types for the single-line bus slot engine.
// Assumes: operation codes are fixed by the request interface of the top.
package sline_pkg;

    typedef enum logic [1:0] {
        OP_RESET    = 2'b00,
        OP_WRITE    = 2'b01,
        OP_READ     = 2'b10,
        OP_READ_ALT = 2'b11
    } sline_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sline_state_e;

    typedef struct packed {
        logic bit_val;
        logic presence;
        logic fault;
    } sline_rsp_t;

endpackage

// File: rtl/sline_sync.sv
// Multi-flop synchronizer for the raw line level.
// Assumes: STAGES >= 2; the idle line is high, so the flops reset to 1.
module sline_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sline_us_tick.sv
// Microsecond strobe generator: one-cycle tick every CYC_PER_US clocks.
// Assumes: 'restart' realigns the phase so that the first tick comes
// CYC_PER_US clocks after the restart edge.
module sline_us_tick #(
    parameter int CYC_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count clocks within one microsecond; wrap on tick, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (CYC_PER_US > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/sline_phase_calc.sv
// Decodes a request into its low-phase length and total length in
// microseconds.
// Assumes: all limits fit UW bits; the extension applies to slots only.
module sline_phase_calc
    import sline_pkg::*;
#(
    parameter int UW          = 11,
    parameter int EXTRA_W     = 8,
    parameter int RST_LOW_US  = 480,
    parameter int RST_REL_US  = 480,
    parameter int WR1_LOW_US  = 6,
    parameter int WR0_LOW_US  = 60,
    parameter int RD_LOW_US   = 6,
    parameter int SLOT_US     = 60,
    parameter int REC_US      = 10
) (
    input  sline_op_e          op,
    input  logic               wbit,
    input  logic [EXTRA_W-1:0] extra_us,
    output logic [UW-1:0]      low_us,
    output logic [UW-1:0]      end_us
);
    localparam logic [UW-1:0] SLOT_BASE = UW'(SLOT_US + REC_US);
    localparam logic [UW-1:0] RST_END   = UW'(RST_LOW_US + RST_REL_US);

    logic [UW-1:0] slot_end;

    // Slot length is the base slot plus the requested recovery extension.
    always_comb begin
        slot_end = SLOT_BASE + UW'(extra_us);
    end

    // Select the pull-low length and the end point per operation.
    always_comb begin
        unique case (op)
            OP_RESET: begin
                low_us = UW'(RST_LOW_US);
                end_us = RST_END;
            end
            OP_WRITE: begin
                low_us = wbit ? UW'(WR1_LOW_US) : UW'(WR0_LOW_US);
                end_us = slot_end;
            end
            default: begin
                low_us = UW'(RD_LOW_US);
                end_us = slot_end;
            end
        endcase
    end

endmodule

// File: rtl/sline_seq.sv
// Operation sequencer: accepts a request, drives the pull-down, counts
// microseconds, watches for presence or samples a read bit, and issues a
// one-cycle response.
// Assumes: tick restarts on acceptance; line_s is already synchronized.
module sline_seq
    import sline_pkg::*;
#(
    parameter int UW           = 11,
    parameter int RST_LOW_US   = 480,
    parameter int PRES_LO_US   = 15,
    parameter int PRES_HI_US   = 300,
    parameter int RD_SAMPLE_US = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  sline_op_e     req_op,
    input  logic [UW-1:0] dec_low_us,
    input  logic [UW-1:0] dec_end_us,
    input  logic          tick,
    input  logic          line_s,
    output logic          accept,
    output logic          idle,
    output logic          pull_low,
    output logic          rsp_valid,
    output sline_rsp_t    rsp
);
    localparam logic [UW-1:0] WIN_LO = UW'(RST_LOW_US + PRES_LO_US);
    localparam logic [UW-1:0] WIN_HI = UW'(RST_LOW_US + PRES_HI_US);
    localparam logic [UW-1:0] SAMPLE = UW'(RD_SAMPLE_US);

    sline_state_e  state;
    sline_op_e     op_q;
    logic [UW-1:0] low_q;
    logic [UW-1:0] end_q;
    logic [UW-1:0] us_q;
    logic [UW-1:0] us_next;
    logic          saw_low_q;
    logic          bit_q;
    logic          is_reset_q;
    logic          in_window;

    assign idle       = (state == ST_IDLE);
    assign accept     = req_valid && idle;
    assign us_next    = us_q + 1'b1;
    assign is_reset_q = (op_q == OP_RESET);
    assign in_window  = (us_next >= WIN_LO) && (us_next < WIN_HI);

    // Main sequencing: accept, advance per tick, finish at the end point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= OP_RESET;
            low_q     <= '0;
            end_q     <= '0;
            us_q      <= '0;
            pull_low  <= 1'b0;
            saw_low_q <= 1'b0;
            bit_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                state     <= ST_BUSY;
                op_q      <= req_op;
                low_q     <= dec_low_us;
                end_q     <= dec_end_us;
                us_q      <= '0;
                pull_low  <= 1'b1;
                saw_low_q <= 1'b0;
                bit_q     <= 1'b0;
            end else if (state == ST_BUSY && tick) begin
                us_q <= us_next;
                if (us_next == low_q) begin
                    pull_low <= 1'b0;
                end
                if (is_reset_q && in_window && !line_s) begin
                    saw_low_q <= 1'b1;
                end
                if (!is_reset_q && op_q != OP_WRITE && us_next == SAMPLE) begin
                    bit_q <= line_s;
                end
                if (us_next == end_q) begin
                    state        <= ST_IDLE;
                    rsp_valid    <= 1'b1;
                    rsp.bit_val  <= bit_q;
                    rsp.presence <= is_reset_q && saw_low_q;
                    rsp.fault    <= is_reset_q && !saw_low_q;
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pull_low); // R2
    AST_ACCEPT_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pull_low); // R3
    AST_RSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!pull_low && state == ST_IDLE)); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (us_q <= end_q)); // R7
    AST_PRES_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(saw_low_q) |-> (us_q >= WIN_LO && us_q < WIN_HI)); // R4
    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp.presence && rsp.fault)); // R4

endmodule

// File: rtl/sline_slot_engine.sv
// Top of the single-line open-drain bus slot engine: bus reset with
// presence check, bit write and bit read slots, microsecond timing.
// Assumes: the pad pulls low while bus_pull_low is 1 and otherwise floats
// to an external pull-up; CLK_HZ is a whole number of MHz.
module sline_slot_engine
    import sline_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int RST_LOW_US   = 480,
    parameter int RST_REL_US   = 480,
    parameter int PRES_LO_US   = 15,
    parameter int PRES_HI_US   = 300,
    parameter int WR1_LOW_US   = 6,
    parameter int WR0_LOW_US   = 60,
    parameter int RD_LOW_US    = 6,
    parameter int RD_SAMPLE_US = 15,
    parameter int SLOT_US      = 60,
    parameter int REC_US       = 10,
    parameter int EXTRA_W      = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic               req_bit,
    input  logic [EXTRA_W-1:0] rec_extra_us,
    output logic               rsp_valid,
    output logic               rsp_bit,
    output logic               rsp_presence,
    output logic               rsp_fault,
    output logic               bus_pull_low,
    input  logic               bus_in
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int MAX_US     = RST_LOW_US + RST_REL_US + SLOT_US + REC_US + (1 << EXTRA_W);
    localparam int UW         = $clog2(MAX_US + 1);

    logic          line_s;
    logic          tick;
    logic          accept;
    logic          idle;
    logic [UW-1:0] dec_low_us;
    logic [UW-1:0] dec_end_us;
    sline_rsp_t    rsp;
    sline_op_e     op_in;

    assign op_in = sline_op_e'(req_op);

    sline_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_in),
        .dout (line_s)
    );

    sline_us_tick #(.CYC_PER_US(CYC_PER_US)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(accept),
        .tick   (tick)
    );

    sline_phase_calc #(
        .UW        (UW),
        .EXTRA_W   (EXTRA_W),
        .RST_LOW_US(RST_LOW_US),
        .RST_REL_US(RST_REL_US),
        .WR1_LOW_US(WR1_LOW_US),
        .WR0_LOW_US(WR0_LOW_US),
        .RD_LOW_US (RD_LOW_US),
        .SLOT_US   (SLOT_US),
        .REC_US    (REC_US)
    ) i_calc (
        .op      (op_in),
        .wbit    (req_bit),
        .extra_us(rec_extra_us),
        .low_us  (dec_low_us),
        .end_us  (dec_end_us)
    );

    sline_seq #(
        .UW          (UW),
        .RST_LOW_US  (RST_LOW_US),
        .PRES_LO_US  (PRES_LO_US),
        .PRES_HI_US  (PRES_HI_US),
        .RD_SAMPLE_US(RD_SAMPLE_US)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op_in),
        .dec_low_us(dec_low_us),
        .dec_end_us(dec_end_us),
        .tick      (tick),
        .line_s    (line_s),
        .accept    (accept),
        .idle      (idle),
        .pull_low  (bus_pull_low),
        .rsp_valid (rsp_valid),
        .rsp       (rsp)
    );

    assign req_ready    = idle;
    assign rsp_bit      = rsp.bit_val;
    assign rsp_presence = rsp.presence;
    assign rsp_fault    = rsp.fault;

    AST_RESET_RELEASES: assert property (@(posedge clk)
        !rst_n |=> (!bus_pull_low && req_ready && !rsp_valid)); // R9
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low |-> !req_ready); // R8

endmodule

// File: tb/test_sline_slot_engine.sv
// Self-checking bench with a behavioural timing model compared every clock.
module test_sline_slot_engine;
    localparam int CYC = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic       req_bit = 1'b0;
    logic [7:0] rec_extra_us = 8'd0;
    logic       req_ready, rsp_valid, rsp_bit, rsp_presence, rsp_fault;
    logic       bus_pull_low;
    logic       slave_low = 1'b0;
    wire        bus_in = !(bus_pull_low || slave_low);

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // Model state
    bit m_busy = 1'b0;
    bit m_rsp = 1'b0;
    int m_c = 0;
    int m_low = 0;
    int m_end = 0;
    int sl_from = 0;
    int sl_to = 0;
    bit exp_bit = 1'b0;
    bit exp_pres = 1'b0;
    bit exp_fault = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    sline_slot_engine i_sline_slot_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_bit     (req_bit),
        .rec_extra_us(rec_extra_us),
        .rsp_valid   (rsp_valid),
        .rsp_bit     (rsp_bit),
        .rsp_presence(rsp_presence),
        .rsp_fault   (rsp_fault),
        .bus_pull_low(bus_pull_low),
        .bus_in      (bus_in)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Behavioural timing model: elapsed clocks since acceptance.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 1'b0;
            m_rsp = 1'b0;
            m_c = 0;
        end else begin
            m_rsp = 1'b0;
            if (m_busy) begin
                m_c++;
                if (m_c == m_end) begin
                    m_busy = 1'b0;
                    m_rsp = 1'b1;
                end
            end else if (req_valid) begin
                m_busy = 1'b1;
                m_c = 0;
                if (req_op == 2'b00) begin
                    m_low = 480 * CYC;
                    m_end = 960 * CYC;
                end else begin
                    m_low = (req_op == 2'b01 && !req_bit) ? 60 * CYC : 6 * CYC;
                    m_end = (70 + int'(rec_extra_us)) * CYC;
                end
            end
        end
        slave_low <= m_busy && (m_c >= sl_from) && (m_c < sl_to);
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check("R2/R3/R5/R9", "bus_pull_low", int'(bus_pull_low),
                  int'(m_busy && m_c < m_low));
            check("R7/R8", "req_ready", int'(req_ready), int'(!m_busy));
            check("R7/R8", "rsp_valid", int'(rsp_valid), int'(m_rsp));
            if (rsp_valid && m_rsp) begin
                check(cur_req, "rsp_bit", int'(rsp_bit), int'(exp_bit));
                check(cur_req, "rsp_presence", int'(rsp_presence), int'(exp_pres));
                check(cur_req, "rsp_fault", int'(rsp_fault), int'(exp_fault));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!done && cycles < 199000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<199000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Issue one operation with a device pulse [from_us,to_us) after acceptance.
    task automatic run_op(input string req, input logic [1:0] op, input logic b,
                          input logic [7:0] extra, input int from_us, input int to_us,
                          input bit eb, input bit ep, input bit ef);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_req = req;
        sl_from = from_us * CYC;
        sl_to = to_us * CYC;
        exp_bit = eb;
        exp_pres = ep;
        exp_fault = ef;
        req_op = op;
        req_bit = b;
        rec_extra_us = extra;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!m_busy) @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "bus_pull_low", int'(bus_pull_low), 0);
        check("R1", "req_ready", int'(req_ready), 1);
        check("R1", "rsp_valid", int'(rsp_valid), 0);
        chk_on = 1'b1;

        // R5: write one and write zero
        run_op("R5", 2'b01, 1'b1, 8'd0, 0, 0, 1'b0, 1'b0, 1'b0);
        // R8: during a write-zero slot, a stray request is ignored
        fork
            run_op("R5", 2'b01, 1'b0, 8'd0, 0, 0, 1'b0, 1'b0, 1'b0);
            begin
                repeat (25 * CYC) @(negedge clk);
                req_op = 2'b00;
                req_valid = 1'b1;
                repeat (10) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        // R6: read zero, read one, short device pulse reads one, alternate code
        run_op("R6", 2'b10, 1'b0, 8'd0, 0, 30, 1'b0, 1'b0, 1'b0);
        run_op("R6", 2'b10, 1'b0, 8'd0, 0, 0, 1'b1, 1'b0, 1'b0);
        run_op("R6", 2'b10, 1'b0, 8'd0, 0, 12, 1'b1, 1'b0, 1'b0);
        run_op("R6", 2'b11, 1'b0, 8'd0, 0, 30, 1'b0, 1'b0, 1'b0);
        // R7: extended recovery on a write and a read
        run_op("R7", 2'b01, 1'b1, 8'd25, 0, 0, 1'b0, 1'b0, 1'b0);
        run_op("R7", 2'b10, 1'b0, 8'd25, 0, 30, 1'b0, 1'b0, 1'b0);

        // R3/R4: presence inside the window
        run_op("R4", 2'b00, 1'b0, 8'd40, 510, 630, 1'b0, 1'b1, 1'b0);
        // R4: pulse too early after release gives a fault
        run_op("R4", 2'b00, 1'b0, 8'd0, 482, 491, 1'b0, 1'b0, 1'b1);
        // R4: pulse too late gives a fault
        run_op("R4", 2'b00, 1'b0, 8'd0, 800, 880, 1'b0, 1'b0, 1'b1);

        // R9: reset in the middle of a bus reset releases the line
        @(negedge clk);
        req_op = 2'b00;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (100 * CYC) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "bus_pull_low after reset", int'(bus_pull_low), 0);
        check("R9", "req_ready after reset", int'(req_ready), 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check("R9", "no response after abort", int'(rsp_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule